// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the state changes of a hart at the moment a trap is taken. A one-cycle strobe presents a trap together with its asynchronous flag, its cause code, the faulting address and the program counter of the trapping instruction. From the current privilege level and from two delegation masks (one for interrupts, one for exceptions), the unit chooses whether the trap lands in supervisor or in machine mode. In the same clock edge it writes that mode's cause, exception PC and trap-value registers. It also stacks the interrupt-enable and privilege fields of the status word, loads the program counter from the matching trap vector, switches privilege and drops any outstanding load reservation.

The rest of the hart sets the privilege level and the two global enables through a context-load port. Return instructions and CSR writes use that port. The unit also keeps the single load-reservation flag that a load-reserved instruction sets. The register width is a parameter and defaults to 32 bits.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap is handled in supervisor mode (priv code 1) only if the current privilege is user (0) or supervisor (1) and the delegation bit indexed by the effective cause code is set. That bit comes from `ideleg_mask` for asynchronous traps and from `edeleg_mask` for synchronous ones. Every other trap, including every trap taken in machine mode (3), goes to machine mode.
- R2: The cause register of the target mode receives the effective cause code in its low bits, with bit XLEN-1 equal to the asynchronous flag and all other bits zero.
- R3: On entry to supervisor mode, `s_pie` takes `s_ie`, `s_pp` takes bit 0 of the old privilege, and `s_ie` is cleared. On entry to machine mode, `m_pie` takes `m_ie`, `m_pp` takes the old privilege, and `m_ie` is cleared.
- R4: `pc_next` becomes the target trap vector with bits 1:0 cleared. If the vector's bits 1:0 equal 1 and the trap is asynchronous, 4 times the cause code is added.
- R5: The exception PC register of the target mode captures `trap_pc`.
- R6: For a synchronous trap whose code is 0, 1, 4, 5, 6, 7, 12, 13 or 15, the trap-value register of the target mode receives `trap_addr`. For every other trap, including all asynchronous ones, it receives zero.
- R7: A synchronous trap with code 8 is an environment call. Its effective code is 8 from user, 9 from supervisor and 11 from machine mode, and this renumbered code selects the delegation bit. Asynchronous code 8 is not renumbered.
- R8: After a trap, `cur_priv` equals the target mode. `resv_valid` is set one cycle after `resv_set`, and it is cleared by any trap or context load.
- R9: A trap leaves the cause, exception PC and trap-value registers of the non-target mode unchanged. With neither a trap nor a context load, all state holds.
- R10: Reset gives machine privilege, all status bits zero (`m_pp` = 0), all cause, PC and trap-value registers zero, `pc_next` equal to `RESET_PC` and no reservation.
- R11: A context load sets privilege, `m_ie` and `s_ie`. Privilege code 2 is stored as user (0). When a trap and a context load arrive in the same cycle, the trap is taken and the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load | input | 1 | Load privilege and global enables |
| ctx_priv | input | 2 | Privilege to load |
| ctx_mie | input | 1 | Machine global enable to load |
| ctx_sie | input | 1 | Supervisor global enable to load |
| resv_set | input | 1 | Load-reserved executed; set the reservation |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_async | input | 1 | Trap is an interrupt |
| trap_code | input | $clog2(XLEN) | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| ideleg_mask | input | XLEN | Interrupt delegation mask |
| edeleg_mask | input | XLEN | Exception delegation mask |
| mtvec | input | XLEN | Machine trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| cur_priv | output | 2 | Current privilege |
| m_ie | output | 1 | Machine global enable |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine previous privilege |
| s_ie | output | 1 | Supervisor global enable |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor previous privilege |
| mcause_q | output | XLEN | Machine cause |
| mepc_q | output | XLEN | Machine exception PC |
| mtval_q | output | XLEN | Machine trap value |
| scause_q | output | XLEN | Supervisor cause |
| sepc_q | output | XLEN | Supervisor exception PC |
| stval_q | output | XLEN | Supervisor trap value |
| pc_next | output | XLEN | Program counter after the last trap |
| resv_valid | output | 1 | Load reservation outstanding |

## Verification
The cycle-by-cycle properties cover the following:
- a trap from machine mode stays in machine mode;
- the target mode's enable is cleared;
- the exception PC and the cause's interrupt bit track the strobe;
- the reservation drops on every trap;
- state is stable when idle;
- privilege code 2 never appears.

The bench's scenarios are needed for everything that depends on matching a mask bit against a cause:
- the delegation choice itself;
- renumbering of environment calls and which delegation bit they consult;
- the vectored offset and its restriction to interrupts;
- which codes capture the address.

It also shows that the other mode's bank is untouched and that a trap wins over a context load.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        logic  mie;
        logic  mpie;
        priv_e mpp;
        logic  sie;
        logic  spie;
        logic  spp;
    } status_t;

    localparam int unsigned ECALL_RAW = 8;

    // Privilege code 2 is not implemented; fold it onto user mode.
    function automatic priv_e priv_sanitize(input logic [1:0] p);
        priv_e r;
        case (p)
            2'd1:    r = PRIV_S;
            2'd3:    r = PRIV_M;
            default: r = PRIV_U;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] ecall_code(input priv_e p);
        logic [3:0] r;
        case (p)
            PRIV_S:  r = 4'd9;
            PRIV_M:  r = 4'd11;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

    // Misaligned, access-fault and page-fault causes report an address.
    function automatic logic code_carries_addr(input int unsigned c);
        logic r;
        case (c)
            0, 1, 4, 5, 6, 7, 12, 13, 15: r = 1'b1;
            default:                      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int CW = $clog2(XLEN)
) (
    input  priv_e           priv,
    input  logic            async_i,
    input  logic [CW-1:0]   code_i,
    input  logic [XLEN-1:0] ideleg,
    input  logic [XLEN-1:0] edeleg,
    output logic [CW-1:0]   eff_code,
    output logic            to_s,
    output logic            carries_addr
);
    logic [XLEN-1:0] mask;
    logic            is_ecall;

    always_comb begin
        is_ecall = !async_i && (code_i == CW'(ECALL_RAW));
        eff_code = is_ecall ? CW'(ecall_code(priv)) : code_i;
        mask     = async_i ? ideleg : edeleg;
        to_s     = (priv == PRIV_U || priv == PRIV_S) && mask[eff_code];
        carries_addr = !async_i && code_carries_addr(int'(unsigned'(eff_code)));
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN        = 32,
    parameter bit VECTORED_EN = 1'b1,
    localparam int CW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] tvec,
    input  logic            async_i,
    input  logic [CW-1:0]   code_i,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] base;
    assign base = {tvec[XLEN-1:2], 2'b00};

    generate
        if (VECTORED_EN) begin : g_vec
            logic [XLEN-1:0] offs;
            always_comb begin
                offs = '0;
                if (async_i && tvec[1:0] == 2'b01)
                    offs = XLEN'({code_i, 2'b00});
                target = base + offs;
            end
        end else begin : g_direct
            assign target = base;
        end
    endgenerate
endmodule

// File: rtl/trap_state.sv
module trap_state
    import trap_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    localparam int CW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctx_load,
    input  priv_e           ctx_priv,
    input  logic            ctx_mie,
    input  logic            ctx_sie,
    input  logic            resv_set,
    input  logic            trap_valid,
    input  logic            trap_async,
    input  logic            to_s,
    input  logic [CW-1:0]   eff_code,
    input  logic [XLEN-1:0] tval_in,
    input  logic [XLEN-1:0] epc_in,
    input  logic [XLEN-1:0] target_pc,
    output priv_e           priv_q,
    output status_t         stat_q,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] mtval,
    output logic [XLEN-1:0] scause,
    output logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] stval,
    output logic [XLEN-1:0] pc_q,
    output logic            resv_q
);
    localparam int PAD = XLEN - 1 - CW;

    logic [XLEN-1:0] cause_word;
    assign cause_word = {trap_async, {PAD{1'b0}}, eff_code};

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= PRIV_M;
            stat_q <= '{mie: 1'b0, mpie: 1'b0, mpp: PRIV_U,
                        sie: 1'b0, spie: 1'b0, spp: 1'b0};
            mcause <= '0;
            mepc   <= '0;
            mtval  <= '0;
            scause <= '0;
            sepc   <= '0;
            stval  <= '0;
            pc_q   <= RESET_PC;
            resv_q <= 1'b0;
        end else if (trap_valid) begin
            resv_q <= 1'b0;
            pc_q   <= target_pc;
            if (to_s) begin
                stat_q.spie <= stat_q.sie;
                stat_q.spp  <= priv_q[0];
                stat_q.sie  <= 1'b0;
                scause      <= cause_word;
                sepc        <= epc_in;
                stval       <= tval_in;
                priv_q      <= PRIV_S;
            end else begin
                stat_q.mpie <= stat_q.mie;
                stat_q.mpp  <= priv_q;
                stat_q.mie  <= 1'b0;
                mcause      <= cause_word;
                mepc        <= epc_in;
                mtval       <= tval_in;
                priv_q      <= PRIV_M;
            end
        end else if (ctx_load) begin
            priv_q     <= ctx_priv;
            stat_q.mie <= ctx_mie;
            stat_q.sie <= ctx_sie;
            resv_q     <= 1'b0;
        end else if (resv_set) begin
            resv_q <= 1'b1;
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter bit              VECTORED_EN = 1'b1,
    parameter logic [XLEN-1:0] RESET_PC    = '0,
    localparam int CW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctx_load,
    input  logic [1:0]      ctx_priv,
    input  logic            ctx_mie,
    input  logic            ctx_sie,
    input  logic            resv_set,
    input  logic            trap_valid,
    input  logic            trap_async,
    input  logic [CW-1:0]   trap_code,
    input  logic [XLEN-1:0] trap_addr,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] ideleg_mask,
    input  logic [XLEN-1:0] edeleg_mask,
    input  logic [XLEN-1:0] mtvec,
    input  logic [XLEN-1:0] stvec,
    output logic [1:0]      cur_priv,
    output logic            m_ie,
    output logic            m_pie,
    output logic [1:0]      m_pp,
    output logic            s_ie,
    output logic            s_pie,
    output logic            s_pp,
    output logic [XLEN-1:0] mcause_q,
    output logic [XLEN-1:0] mepc_q,
    output logic [XLEN-1:0] mtval_q,
    output logic [XLEN-1:0] scause_q,
    output logic [XLEN-1:0] sepc_q,
    output logic [XLEN-1:0] stval_q,
    output logic [XLEN-1:0] pc_next,
    output logic            resv_valid
);
    priv_e           priv_q;
    status_t         stat_q;
    logic [CW-1:0]   eff_code;
    logic            to_s;
    logic            carries_addr;
    logic [XLEN-1:0] sel_tvec;
    logic [XLEN-1:0] target_pc;
    logic [XLEN-1:0] tval_in;

    trap_route #(.XLEN(XLEN)) u_route (
        .priv         (priv_q),
        .async_i      (trap_async),
        .code_i       (trap_code),
        .ideleg       (ideleg_mask),
        .edeleg       (edeleg_mask),
        .eff_code     (eff_code),
        .to_s         (to_s),
        .carries_addr (carries_addr)
    );

    assign sel_tvec = to_s ? stvec : mtvec;
    assign tval_in  = carries_addr ? trap_addr : '0;

    trap_vector #(.XLEN(XLEN), .VECTORED_EN(VECTORED_EN)) u_vector (
        .tvec    (sel_tvec),
        .async_i (trap_async),
        .code_i  (eff_code),
        .target  (target_pc)
    );

    trap_state #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_state (
        .clk        (clk),
        .rst        (rst),
        .ctx_load   (ctx_load),
        .ctx_priv   (priv_sanitize(ctx_priv)),
        .ctx_mie    (ctx_mie),
        .ctx_sie    (ctx_sie),
        .resv_set   (resv_set),
        .trap_valid (trap_valid),
        .trap_async (trap_async),
        .to_s       (to_s),
        .eff_code   (eff_code),
        .tval_in    (tval_in),
        .epc_in     (trap_pc),
        .target_pc  (target_pc),
        .priv_q     (priv_q),
        .stat_q     (stat_q),
        .mcause     (mcause_q),
        .mepc       (mepc_q),
        .mtval      (mtval_q),
        .scause     (scause_q),
        .sepc       (sepc_q),
        .stval      (stval_q),
        .pc_q       (pc_next),
        .resv_q     (resv_valid)
    );

    assign cur_priv = priv_q;
    assign m_ie     = stat_q.mie;
    assign m_pie    = stat_q.mpie;
    assign m_pp     = stat_q.mpp;
    assign s_ie     = stat_q.sie;
    assign s_pie    = stat_q.spie;
    assign s_pp     = stat_q.spp;
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            ctx_load,
    input logic            trap_valid,
    input logic            trap_async,
    input logic [XLEN-1:0] trap_pc,
    input logic [1:0]      cur_priv,
    input logic            m_ie,
    input logic            s_ie,
    input logic [XLEN-1:0] mcause_q,
    input logic [XLEN-1:0] scause_q,
    input logic [XLEN-1:0] mepc_q,
    input logic [XLEN-1:0] sepc_q,
    input logic [XLEN-1:0] pc_next,
    input logic            resv_valid
);
    assert_m_stays_R1: assert property (@(posedge clk) disable iff (rst)
        trap_valid && cur_priv == 2'd3 |=> cur_priv == 2'd3);

    assert_enable_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (cur_priv == 2'd3 ? !m_ie : !s_ie));

    assert_cause_msb_R2: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (cur_priv == 2'd3 ? mcause_q[XLEN-1] == $past(trap_async)
                                         : scause_q[XLEN-1] == $past(trap_async)));

    assert_epc_capture_R5: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (cur_priv == 2'd3 ? mepc_q == $past(trap_pc)
                                         : sepc_q == $past(trap_pc)));

    assert_resv_drop_R8: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> !resv_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !trap_valid && !ctx_load |=> $stable(mcause_q) && $stable(scause_q)
                                     && $stable(cur_priv) && $stable(pc_next));

    assert_priv_legal_R11: assert property (@(posedge clk) disable iff (rst)
        cur_priv != 2'd2);
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .ctx_load   (ctx_load),
    .trap_valid (trap_valid),
    .trap_async (trap_async),
    .trap_pc    (trap_pc),
    .cur_priv   (cur_priv),
    .m_ie       (m_ie),
    .s_ie       (s_ie),
    .mcause_q   (mcause_q),
    .scause_q   (scause_q),
    .mepc_q     (mepc_q),
    .sepc_q     (sepc_q),
    .pc_next    (pc_next),
    .resv_valid (resv_valid)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
    localparam int XLEN = 32;
    localparam int CW   = $clog2(XLEN);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ctx_load = 1'b0;
    logic [1:0]      ctx_priv = '0;
    logic            ctx_mie = 1'b0, ctx_sie = 1'b0, resv_set = 1'b0;
    logic            trap_valid = 1'b0, trap_async = 1'b0;
    logic [CW-1:0]   trap_code = '0;
    logic [XLEN-1:0] trap_addr = '0, trap_pc = '0;
    logic [XLEN-1:0] ideleg_mask = '0, edeleg_mask = '0, mtvec = '0, stvec = '0;
    logic [1:0]      cur_priv, m_pp;
    logic            m_ie, m_pie, s_ie, s_pie, s_pp, resv_valid;
    logic [XLEN-1:0] mcause_q, mepc_q, mtval_q, scause_q, sepc_q, stval_q, pc_next;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) dut (.*);

    typedef struct packed {
        logic [1:0]  cp;
        logic        cm;
        logic        cs;
        logic        as_;
        logic [4:0]  cd;
        logic [31:0] ed;
        logic [31:0] id;
        logic [31:0] mt;
        logic [31:0] st;
        logic        exp_s;
        logic [31:0] exp_cause;
        logic        tva;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b1,1'b1,1'b0,5'd2, 32'h4,      32'h0,    32'h1001,32'h2000,1'b1,32'h2,        1'b0,32'h2000},
        '{2'd0,1'b1,1'b0,1'b0,5'd13,32'h0,      32'h0,    32'h1001,32'h2000,1'b0,32'hD,        1'b1,32'h1000},
        '{2'd1,1'b0,1'b1,1'b1,5'd5, 32'h0,      32'h20,   32'h1001,32'h2001,1'b1,32'h80000005, 1'b0,32'h2014},
        '{2'd3,1'b1,1'b1,1'b1,5'd5, 32'h0,      32'h20,   32'h1001,32'h2001,1'b0,32'h80000005, 1'b0,32'h1014},
        '{2'd0,1'b0,1'b1,1'b0,5'd8, 32'h100,    32'h0,    32'h1001,32'h2000,1'b1,32'h8,        1'b0,32'h2000},
        '{2'd1,1'b1,1'b0,1'b0,5'd8, 32'h100,    32'h0,    32'h1001,32'h2000,1'b0,32'h9,        1'b0,32'h1000},
        '{2'd3,1'b0,1'b0,1'b0,5'd8, 32'hFFFFFFFF,32'h0,   32'h1001,32'h2000,1'b0,32'hB,        1'b0,32'h1000},
        '{2'd1,1'b0,1'b1,1'b0,5'd8, 32'h200,    32'h0,    32'h1001,32'h2000,1'b1,32'h9,        1'b0,32'h2000},
        '{2'd0,1'b1,1'b1,1'b1,5'd8, 32'h0,      32'h0,    32'h1001,32'h2000,1'b0,32'h80000008, 1'b0,32'h1020},
        '{2'd1,1'b0,1'b1,1'b0,5'd4, 32'h10,     32'h0,    32'h1001,32'h2001,1'b1,32'h4,        1'b1,32'h2000},
        '{2'd0,1'b1,1'b0,1'b1,5'd11,32'h0,      32'h0,    32'h1003,32'h2000,1'b0,32'h8000000B, 1'b0,32'h1000},
        '{2'd1,1'b1,1'b1,1'b0,5'd15,32'h8000,   32'h0,    32'h1001,32'h2005,1'b1,32'hF,        1'b1,32'h2004}
    };

    task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ctx(input logic [1:0] p, input logic mi, input logic si);
        @(negedge clk);
        ctx_load = 1'b1; ctx_priv = p; ctx_mie = mi; ctx_sie = si;
        @(negedge clk);
        ctx_load = 1'b0;
    endtask

    task automatic trap(input logic a, input logic [CW-1:0] c,
                        input logic [XLEN-1:0] ad, input logic [XLEN-1:0] pc);
        trap_valid = 1'b1; trap_async = a; trap_code = c; trap_addr = ad; trap_pc = pc;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [XLEN-1:0] m_c, m_e, m_t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 priv", XLEN'(cur_priv), 32'd3);
        chk("R10 status", XLEN'({m_ie, m_pie, m_pp, s_ie, s_pie, s_pp}), 32'd0);
        chk("R10 mcause", mcause_q, 32'd0);
        chk("R10 scause", scause_q, 32'd0);
        chk("R10 pc", pc_next, 32'd0);
        chk("R10 resv", XLEN'(resv_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [XLEN-1:0] addr, pc;
            v = VECS[i];
            addr = 32'hA000_0000 + 32'(i) * 16;
            pc   = 32'h8000_0000 + 32'(i) * 4;
            edeleg_mask = v.ed; ideleg_mask = v.id; mtvec = v.mt; stvec = v.st;
            ctx(v.cp, v.cm, v.cs);
            trap(v.as_, v.cd, addr, pc);
            // R1 R7 target, R8 privilege
            chk($sformatf("R1 R8 vec%0d priv", i), XLEN'(cur_priv), v.exp_s ? 32'd1 : 32'd3);
            chk($sformatf("R4 vec%0d pc", i), pc_next, v.exp_pc);
            if (v.exp_s) begin
                chk($sformatf("R2 R7 vec%0d scause", i), scause_q, v.exp_cause);
                chk($sformatf("R5 vec%0d sepc", i), sepc_q, pc);
                chk($sformatf("R6 vec%0d stval", i), stval_q, v.tva ? addr : 32'd0);
                chk($sformatf("R3 vec%0d sstat", i), XLEN'({s_ie, s_pie, s_pp}),
                    XLEN'({1'b0, v.cs, v.cp[0]}));
            end else begin
                chk($sformatf("R2 R7 vec%0d mcause", i), mcause_q, v.exp_cause);
                chk($sformatf("R5 vec%0d mepc", i), mepc_q, pc);
                chk($sformatf("R6 vec%0d mtval", i), mtval_q, v.tva ? addr : 32'd0);
                chk($sformatf("R3 vec%0d mstat", i), XLEN'({m_ie, m_pie, m_pp}),
                    XLEN'({1'b0, v.cm, v.cp}));
            end
        end

        // R8: reservation set then cleared by a trap
        ctx(2'd0, 1'b0, 1'b0);
        resv_set = 1'b1;
        @(negedge clk);
        resv_set = 1'b0;
        chk("R8 resv set", XLEN'(resv_valid), 32'd1);
        edeleg_mask = 32'h0; mtvec = 32'h3000;
        trap(1'b0, 5'd3, 32'h0, 32'h44);
        chk("R8 resv cleared by trap", XLEN'(resv_valid), 32'd0);
        // R8: reservation cleared by context load
        resv_set = 1'b1;
        @(negedge clk);
        resv_set = 1'b0;
        ctx(2'd3, 1'b0, 1'b0);
        chk("R8 resv cleared by load", XLEN'(resv_valid), 32'd0);

        // R9: supervisor trap leaves machine bank alone
        m_c = mcause_q; m_e = mepc_q; m_t = mtval_q;
        ctx(2'd0, 1'b1, 1'b1);
        edeleg_mask = 32'h2000; stvec = 32'h2000;
        trap(1'b0, 5'd13, 32'h1234_5678, 32'h9999_0000);
        chk("R9 S target", XLEN'(cur_priv), 32'd1);
        chk("R9 mcause kept", mcause_q, m_c);
        chk("R9 mepc kept", mepc_q, m_e);
        chk("R9 mtval kept", mtval_q, m_t);
        // R9: idle hold
        m_c = pc_next;
        repeat (4) @(negedge clk);
        chk("R9 idle pc", pc_next, m_c);
        chk("R9 idle priv", XLEN'(cur_priv), 32'd1);

        // R11: privilege code 2 is stored as user
        ctx(2'd2, 1'b0, 1'b0);
        chk("R11 priv 2 maps to U", XLEN'(cur_priv), 32'd0);
        // R11: trap wins over simultaneous load
        ctx(2'd3, 1'b1, 1'b0);
        edeleg_mask = 32'hFFFF_FFFF; mtvec = 32'h4000;
        ctx_load = 1'b1; ctx_priv = 2'd0; ctx_mie = 1'b1; ctx_sie = 1'b1;
        trap(1'b0, 5'd2, 32'h0, 32'h50);
        ctx_load = 1'b0;
        chk("R11 trap wins priv", XLEN'(cur_priv), 32'd3);
        chk("R11 trap wins mpp", XLEN'(m_pp), 32'd3);
        chk("R11 trap wins mie", XLEN'(m_ie), 32'd0);
        chk("R11 trap wins sie", XLEN'(s_ie), 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule